// File: doc/BRIEF.md
# Burst Transfer Sequencer

This block is the address-phase generator of a master on a pipelined system bus of the AHB kind. It accepts commands from the master's own logic and turns each one into transfers on the bus. A command carries a start address, a beat count, a direction and a transfer size. The block drives the transfer type, the address and the burst, direction and size controls. Every output comes straight from a register. Throughout the burst, a per-beat readiness strobe decides whether the next beat goes out as a sequential transfer or whether a busy cycle keeps the burst's place on the bus.

When no command is waiting the bus shows idle. A wait state from the slave freezes every output. A master-side abort given while the burst shows busy drops what is left of the burst. The first cycle of a two-cycle error response turns the pending transfer into idle and discards the rest of the burst. In every one of these cases the next command starts with a fresh non-sequential transfer.

Top module: `busBurstSeq`

## Requirements
- R1: During and right after reset, the transfer type is IDLE (2'b00), the address is zero, the burst code is SINGLE (3'b000), and write and size are zero.
- R2: With no command offered and no beats left in a burst, the transfer type is IDLE.
- R3: A command is taken at a clock edge where cmdValid and cmdReady are both high. From that edge the bus shows NONSEQ (2'b10) with the command's address, direction and size. The burst code is SINGLE (3'b000) for a count of 0 or 1 and INCR (3'b001) for a larger count.
- R4: A command with beat count N puts exactly N transfers on the bus: one NONSEQ, then N-1 SEQ (2'b11). A beat count of 0 counts as 1. Each SEQ address is the address of the previous beat plus 2^size bytes.
- R5: In a burst with beats still to issue, beatReady low at an edge where the bus is ready gives BUSY (2'b01). BUSY shows the address of the next beat and leaves direction, size and burst code unchanged. The SEQ that follows a BUSY uses that same address.
- R6: While busReady is low and busResp is low (OKAY), the transfer type, address, burst code, direction and size do not change.
- R7: When the bus leaves IDLE, the first transfer is always NONSEQ.
- R8: cmdAbort high while the bus shows BUSY and busReady is high drops the rest of the burst. At that edge the bus moves to NONSEQ for a command offered in the same cycle, or to IDLE if no command is offered. In any other state cmdAbort has no effect.
- R9: busResp high (ERROR) with busReady low forces the transfer type to IDLE at the next edge and drops the rest of the burst, whatever the state of beatReady.
- R10: After an error response, the next command is carried out normally, starting with NONSEQ.
- R11: cmdReady is low while a burst still has beats to issue (unless an abort from BUSY is being taken), while busReady is low, and while busResp is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is offered |
| cmdReady | output | 1 | The offered command is taken at this edge |
| cmdAddr | input | ADDR_W | Start byte address |
| cmdBeats | input | CNT_W | Beat count, 0 counts as 1 |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdSize | input | 3 | Bytes per beat as log2 |
| beatReady | input | 1 | The next beat of the running burst can go out |
| cmdAbort | input | 1 | Drop the running burst while it shows BUSY |
| busReady | input | 1 | Slave ready, low = wait state |
| busResp | input | 1 | Slave response, 1 = ERROR, 0 = OKAY |
| busTrans | output | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| busAddr | output | ADDR_W | Transfer address |
| busBurst | output | 3 | 000 SINGLE, 001 INCR |
| busWrite | output | 1 | Transfer direction |
| busSize | output | 3 | Transfer size |

## Verification
The bench builds the block with ADDR_W=16 and MAX_BEATS=8. The narrow address keeps the expected values short. The small count lets every beat of a burst be checked one by one, with no loops over long bursts. With these values, bursts with sizes of 1, 2 and 4 bytes fit in a few dozen cycles. So does a zero beat count, along with aborts and error responses placed at chosen beats. Wait states are placed on both a NONSEQ and a SEQ beat.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } transE;

  localparam logic [2:0] BURST_SINGLE = 3'b000;
  localparam logic [2:0] BURST_INCR   = 3'b001;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadCmd;     // capture a new command
    logic stepAddr;    // advance address by one beat
    logic decCount;    // one more beat issued
    logic clearCount;  // drop what is left of the burst
  } seqStrobeT;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busReady,
  input  logic      busResp,
  input  logic      cmdValid,
  input  logic      cmdAbort,
  input  logic      beatReady,
  input  logic      countZero,
  output logic      cmdReady,
  output transE     curTrans,
  output seqStrobeT strobe
);

  transE nextTrans;
  logic  abortNow;
  logic  openBurst;
  logic  issuing;

  assign abortNow  = (curTrans == TR_BUSY) && cmdAbort;
  assign openBurst = !countZero && !abortNow;
  assign issuing   = (curTrans == TR_NONSEQ) || (curTrans == TR_SEQ);
  assign cmdReady  = busReady && !busResp && !openBurst;

  always_comb begin
    nextTrans = curTrans;
    strobe    = '0;
    if (busResp) begin
      // first error cycle cancels the pending beat, second keeps IDLE
      nextTrans         = TR_IDLE;
      strobe.clearCount = 1'b1;
    end else if (busReady) begin
      if (openBurst) begin
        strobe.stepAddr = issuing;
        if (beatReady) begin
          nextTrans       = TR_SEQ;
          strobe.decCount = 1'b1;
        end else begin
          nextTrans = TR_BUSY;
        end
      end else begin
        strobe.clearCount = abortNow;
        if (cmdValid) begin
          nextTrans      = TR_NONSEQ;
          strobe.loadCmd = 1'b1;
        end else begin
          nextTrans = TR_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) curTrans <= TR_IDLE;
    else       curTrans <= nextTrans;
  end

  // R6
  trans_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busReady && !busResp) |=> $stable(curTrans));

  // R7
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curTrans == TR_IDLE) |=> (curTrans == TR_IDLE || curTrans == TR_NONSEQ));

  // R9
  err_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busResp && !busReady) |=> (curTrans == TR_IDLE));

  // R11
  cmd_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busResp || !busReady) |-> !cmdReady);

endmodule

// File: rtl/busSeqPath.sv
module busSeqPath
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNT_W-1:0]  cmdBeats,
  input  logic              cmdWrite,
  input  logic [2:0]        cmdSize,
  output logic [ADDR_W-1:0] busAddr,
  output logic [2:0]        busBurst,
  output logic              busWrite,
  output logic [2:0]        busSize,
  output logic              countZero
);

  localparam logic [ADDR_W-1:0] ONE_BYTE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  ONE_BEAT = CNT_W'(1);

  logic [CNT_W-1:0]  beatsLeft;
  logic [ADDR_W-1:0] stepBytes;

  assign stepBytes = ONE_BYTE << busSize;
  assign countZero = (beatsLeft == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAddr  <= '0;
      busBurst <= BURST_SINGLE;
      busWrite <= 1'b0;
      busSize  <= '0;
    end else if (strobe.loadCmd) begin
      busAddr  <= cmdAddr;
      busBurst <= (cmdBeats > ONE_BEAT) ? BURST_INCR : BURST_SINGLE;
      busWrite <= cmdWrite;
      busSize  <= cmdSize;
    end else if (strobe.stepAddr) begin
      busAddr <= busAddr + stepBytes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  beatsLeft <= '0;
    else if (strobe.loadCmd)    beatsLeft <= (cmdBeats == '0) ? '0 : cmdBeats - ONE_BEAT;
    else if (strobe.clearCount) beatsLeft <= '0;
    else if (strobe.decCount)   beatsLeft <= beatsLeft - ONE_BEAT;
  end

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCount |-> !countZero);

endmodule

// File: rtl/busBurstSeq.sv
module busBurstSeq
  import busSeqPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BEATS = 16,
  localparam int CNT_W    = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNT_W-1:0]  cmdBeats,
  input  logic              cmdWrite,
  input  logic [2:0]        cmdSize,
  input  logic              beatReady,
  input  logic              cmdAbort,
  input  logic              busReady,
  input  logic              busResp,
  output logic [1:0]        busTrans,
  output logic [ADDR_W-1:0] busAddr,
  output logic [2:0]        busBurst,
  output logic              busWrite,
  output logic [2:0]        busSize
);

  seqStrobeT strobe;
  transE     curTrans;
  logic      countZero;

  busSeqCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busReady  (busReady),
    .busResp   (busResp),
    .cmdValid  (cmdValid),
    .cmdAbort  (cmdAbort),
    .beatReady (beatReady),
    .countZero (countZero),
    .cmdReady  (cmdReady),
    .curTrans  (curTrans),
    .strobe    (strobe)
  );

  busSeqPath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdAddr   (cmdAddr),
    .cmdBeats  (cmdBeats),
    .cmdWrite  (cmdWrite),
    .cmdSize   (cmdSize),
    .busAddr   (busAddr),
    .busBurst  (busBurst),
    .busWrite  (busWrite),
    .busSize   (busSize),
    .countZero (countZero)
  );

  assign busTrans = curTrans;

  // R5
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busTrans) == TR_BUSY && busTrans[0]) |->
      ($stable(busAddr) && $stable(busSize) && $stable(busWrite) && $stable(busBurst)));

  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busReady) && !$past(busResp) && $past(busTrans[1]) && busTrans == TR_SEQ) |->
      (busAddr == $past(busAddr) + (ADDR_W'(1) << $past(busSize))));

  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busReady && !busResp) |=>
      ($stable(busAddr) && $stable(busBurst) && $stable(busWrite) && $stable(busSize)));

  // R3
  single_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busTrans == TR_NONSEQ && busBurst == BURST_SINGLE && busReady && !busResp) |=>
      !busTrans[0]);

endmodule

// File: tb/busBurstSeq_test.sv
module busBurstSeq_test;

  localparam int ADDR_W    = 16;
  localparam int MAX_BEATS = 8;
  localparam int CNT_W     = $clog2(MAX_BEATS + 1);

  localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0, cmdReady;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [CNT_W-1:0]  cmdBeats = '0;
  logic              cmdWrite = 1'b0;
  logic [2:0]        cmdSize = '0;
  logic              beatReady = 1'b0, cmdAbort = 1'b0;
  logic              busReady = 1'b1, busResp = 1'b0;
  logic [1:0]        busTrans;
  logic [ADDR_W-1:0] busAddr;
  logic [2:0]        busBurst, busSize;
  logic              busWrite;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  busBurstSeq #(.ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdBeats(cmdBeats), .cmdWrite(cmdWrite), .cmdSize(cmdSize),
    .beatReady(beatReady), .cmdAbort(cmdAbort), .busReady(busReady), .busResp(busResp),
    .busTrans(busTrans), .busAddr(busAddr), .busBurst(busBurst), .busWrite(busWrite),
    .busSize(busSize)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expBus(input string tag, input logic [1:0] tr, input logic [ADDR_W-1:0] ad);
    checkEq({tag, " trans"}, 32'(busTrans), 32'(tr));
    if (tr != T_IDLE) checkEq({tag, " addr"}, 32'(busAddr), 32'(ad));
  endtask

  task automatic offer(input logic [ADDR_W-1:0] a, input int beats, input logic w,
                       input logic [2:0] sz);
    cmdValid = 1'b1;
    cmdAddr  = a;
    cmdBeats = CNT_W'(beats);
    cmdWrite = w;
    cmdSize  = sz;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) tick();
    checkEq("R1 trans", 32'(busTrans), 0);
    checkEq("R1 addr", 32'(busAddr), 0);
    checkEq("R1 burst", 32'(busBurst), 0);
    checkEq("R1 write", 32'(busWrite), 0);
    checkEq("R1 size", 32'(busSize), 0);
    rstN = 1'b1;
    tick();
    checkEq("R1 trans after release", 32'(busTrans), 0);
  endtask

  task automatic testSingle();
    tick();
    expBus("R2 idle", T_IDLE, '0);
    offer(16'h0100, 1, 1'b1, 3'd2);
    #1 checkEq("R3 cmdReady", 32'(cmdReady), 1);
    tick();
    cmdValid = 1'b0;
    expBus("R3 R7 single", T_NSEQ, 16'h0100);
    checkEq("R3 burst single", 32'(busBurst), 0);
    checkEq("R3 write", 32'(busWrite), 1);
    checkEq("R3 size", 32'(busSize), 2);
    tick();
    expBus("R2 idle after single", T_IDLE, '0);
    offer(16'h0010, 0, 1'b0, 3'd0);
    tick();
    cmdValid = 1'b0;
    expBus("R4 zero count", T_NSEQ, 16'h0010);
    checkEq("R3 zero count burst", 32'(busBurst), 0);
    beatReady = 1'b1;
    tick();
    expBus("R4 zero count ends", T_IDLE, '0);
    beatReady = 1'b0;
  endtask

  task automatic testIncr();
    beatReady = 1'b1;
    offer(16'h0200, 4, 1'b0, 3'd2);
    tick();
    cmdValid = 1'b0;
    expBus("R3 incr first", T_NSEQ, 16'h0200);
    checkEq("R3 burst incr", 32'(busBurst), 1);
    #1 checkEq("R11 cmdReady in burst", 32'(cmdReady), 0);
    for (int i = 1; i < 4; i++) begin
      tick();
      expBus("R4 seq word", T_SEQ, 16'(16'h0200 + 4 * i));
    end
    tick();
    expBus("R4 count four", T_IDLE, '0);
    offer(16'h0031, 3, 1'b1, 3'd0);
    tick();
    cmdValid = 1'b0;
    expBus("R4 byte first", T_NSEQ, 16'h0031);
    tick();
    expBus("R4 byte seq", T_SEQ, 16'h0032);
    tick();
    expBus("R4 byte seq last", T_SEQ, 16'h0033);
    tick();
    expBus("R4 count three", T_IDLE, '0);
    beatReady = 1'b0;
  endtask

  task automatic testBusy();
    beatReady = 1'b0;
    offer(16'h0400, 3, 1'b1, 3'd1);
    tick();
    cmdValid = 1'b0;
    expBus("R5 first", T_NSEQ, 16'h0400);
    tick();
    expBus("R5 busy", T_BUSY, 16'h0402);
    checkEq("R5 busy burst", 32'(busBurst), 1);
    checkEq("R5 busy write", 32'(busWrite), 1);
    tick();
    expBus("R5 busy again", T_BUSY, 16'h0402);
    beatReady = 1'b1;
    tick();
    beatReady = 1'b0;
    expBus("R5 seq after busy", T_SEQ, 16'h0402);
    tick();
    expBus("R5 busy mid", T_BUSY, 16'h0404);
    beatReady = 1'b1;
    tick();
    expBus("R5 last seq", T_SEQ, 16'h0404);
    tick();
    expBus("R5 end", T_IDLE, '0);
    beatReady = 1'b0;
  endtask

  task automatic testWait();
    beatReady = 1'b1;
    offer(16'h0500, 2, 1'b0, 3'd2);
    tick();
    cmdValid = 1'b0;
    busReady = 1'b0;
    expBus("R6 first", T_NSEQ, 16'h0500);
    tick();
    expBus("R6 hold nonseq", T_NSEQ, 16'h0500);
    offer(16'h0A0A, 1, 1'b1, 3'd0);
    #1 checkEq("R11 cmdReady in wait", 32'(cmdReady), 0);
    tick();
    cmdValid = 1'b0;
    expBus("R6 hold nonseq 2", T_NSEQ, 16'h0500);
    checkEq("R6 hold size", 32'(busSize), 2);
    busReady = 1'b1;
    tick();
    busReady = 1'b0;
    expBus("R6 seq", T_SEQ, 16'h0504);
    tick();
    expBus("R6 hold seq", T_SEQ, 16'h0504);
    busReady = 1'b1;
    tick();
    expBus("R6 end", T_IDLE, '0);
    beatReady = 1'b0;
  endtask

  task automatic testAbort();
    beatReady = 1'b0;
    offer(16'h0600, 4, 1'b1, 3'd2);
    tick();
    cmdValid = 1'b0;
    expBus("R8 first", T_NSEQ, 16'h0600);
    tick();
    expBus("R8 busy", T_BUSY, 16'h0604);
    cmdAbort = 1'b1;
    offer(16'h0700, 1, 1'b0, 3'd0);
    #1 checkEq("R8 cmdReady on abort", 32'(cmdReady), 1);
    tick();
    cmdAbort = 1'b0;
    cmdValid = 1'b0;
    expBus("R8 fresh nonseq", T_NSEQ, 16'h0700);
    checkEq("R8 fresh burst", 32'(busBurst), 0);
    checkEq("R8 fresh write", 32'(busWrite), 0);
    tick();
    expBus("R8 idle after", T_IDLE, '0);
    offer(16'h0680, 3, 1'b1, 3'd2);
    tick();
    cmdValid = 1'b0;
    tick();
    expBus("R8 busy two", T_BUSY, 16'h0684);
    cmdAbort = 1'b1;
    tick();
    cmdAbort = 1'b0;
    beatReady = 1'b1;
    expBus("R8 abort to idle", T_IDLE, '0);
    tick();
    expBus("R8 burst dropped", T_IDLE, '0);
    cmdAbort = 1'b1;
    offer(16'h0800, 3, 1'b1, 3'd2);
    tick();
    cmdValid = 1'b0;
    expBus("R8 ignored first", T_NSEQ, 16'h0800);
    tick();
    expBus("R8 ignored seq", T_SEQ, 16'h0804);
    tick();
    expBus("R8 ignored seq 2", T_SEQ, 16'h0808);
    tick();
    expBus("R8 ignored end", T_IDLE, '0);
    cmdAbort = 1'b0;
    beatReady = 1'b0;
  endtask

  task automatic testError();
    beatReady = 1'b1;
    offer(16'h0900, 4, 1'b1, 3'd2);
    tick();
    cmdValid = 1'b0;
    expBus("R9 first", T_NSEQ, 16'h0900);
    tick();
    expBus("R9 seq", T_SEQ, 16'h0904);
    busResp = 1'b1;
    busReady = 1'b0;
    tick();
    expBus("R9 cancel", T_IDLE, '0);
    busReady = 1'b1;
    offer(16'h0B00, 1, 1'b0, 3'd0);
    #1 checkEq("R11 cmdReady in error", 32'(cmdReady), 0);
    tick();
    cmdValid = 1'b0;
    busResp = 1'b0;
    expBus("R9 second cycle", T_IDLE, '0);
    tick();
    expBus("R9 burst dropped", T_IDLE, '0);
    offer(16'h0A00, 2, 1'b0, 3'd2);
    tick();
    cmdValid = 1'b0;
    expBus("R10 resume", T_NSEQ, 16'h0A00);
    checkEq("R10 burst", 32'(busBurst), 1);
    tick();
    expBus("R10 seq", T_SEQ, 16'h0A04);
    tick();
    expBus("R10 end", T_IDLE, '0);
    beatReady = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    testReset();
    testSingle();
    testIncr();
    testBusy();
    testWait();
    testAbort();
    testError();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule